// File: doc/BRIEF.md
# Multiphase Phase Manager and Mode Selector

This block schedules up to three interleaved regulator phases from one master clock tick. After reset it spends a short strap window listening to the phase-2 and phase-3 pins: a pin that reads high in that window marks its phase as not populated, and that phase's pin driver stays off for good. Phase 1 is always populated.

Once the window is over, the block chooses on every master tick how many of the populated phases run and how they run. A supply-setpoint move or a current-limit event forces every populated phase into fixed-frequency PWM with continuous conduction. Otherwise a deep-sleep request, or the loss of the full-power request, sheds down to phase 1 alone in ripple-triggered (RPM) mode. Only the deep-sleep case permits discontinuous conduction. The running phases receive one-cycle start ticks in rotation, so each phase runs at the master rate divided by the number of running phases. A multiphase enable output switches the drivers of phases 2 and 3 off when only phase 1 runs.

Top module: `phase_shed_ctrl`

## Requirements
- R1: While reset is high, and until the strap window ends, ph_tick, pin_en, multi_en, mode_rpm, dcm_ok and detect_done are all 0.
- R2: The strap window is the first three master ticks after reset. A strap_hi bit that is high at any of those ticks disables its phase: bit 0 is phase 2, bit 1 is phase 3. detect_done rises in the cycle after the third tick.
- R3: strap_hi is ignored outside the strap window. pin_en does not change until the next reset.
- R4: After the window, pin_en bit i is 1 exactly when phase i+1 is populated. Bit 0 (phase 1) is always 1.
- R5: ph_tick has at most one bit set. A bit is set only in the cycle that follows a master tick taken after the window, and it is set for exactly one cycle.
- R6: Each tick goes to the next running phase after the last one served, in the cyclic order 1, 2, 3. Phases that are not running are skipped. The first tick after reset goes to phase 1.
- R7: When vset_moving or cur_limit is high at a tick, every populated phase runs, mode_rpm is 0 and dcm_ok is 0, whatever full_req and deep_sleep are.
- R8: When neither override is active, full_req is 1 and deep_sleep is 0, every populated phase runs, with mode_rpm = 0 and dcm_ok = 0.
- R9: When neither override is active, full_req is 0 and deep_sleep is 0, only phase 1 runs, with mode_rpm = 1 and dcm_ok = 0.
- R10: When neither override is active and deep_sleep is 1, only phase 1 runs, with mode_rpm = 1 and dcm_ok = 1.
- R11: multi_en is 1 exactly when more than one phase is running. It is 0 in single-phase operation, in reset and during the strap window.
- R12: The mode_rpm, dcm_ok and multi_en outputs change only in the cycle after a master tick, so that a phase count change never cuts a pulse short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Master clock tick, one cycle wide |
| strap_hi | input | NPH-1 | Strap sense for phases 2..NPH, high = not populated |
| full_req | input | 1 | Heavy-load power state request (high = all phases) |
| deep_sleep | input | 1 | Deep sleep request |
| vset_moving | input | 1 | Output setpoint transition in progress |
| cur_limit | input | 1 | Current limit reached |
| ph_tick | output | NPH | Per-phase start tick, one-hot, bit 0 = phase 1 |
| pin_en | output | NPH | Pin driver enable per phase (0 = high impedance) |
| multi_en | output | 1 | High while more than one phase runs |
| mode_rpm | output | 1 | 1 = ripple-triggered mode, 0 = clocked PWM |
| dcm_ok | output | 1 | Discontinuous conduction permitted |
| detect_done | output | 1 | Strap window finished |

## Verification
The assertions assume that tick is never high in two cycles in a row. They also assume that reset is held for at least two cycles, so that the state is known before the first checked edge. The bench raises tick for one cycle, and always leaves at least one idle cycle between ticks. It changes the control flags only on the falling clock edge, in cycles without a tick, so each flag set is decoded at one tick boundary. The sweep runs every strap pattern, with the strap pulse placed at a different window tick each time. For each pattern it tries every combination of the four control flags, over several ticks.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;

  typedef enum logic {
    OP_PWM = 1'b0,
    OP_RPM = 1'b1
  } op_kind_e;

  typedef struct packed {
    logic     single;
    op_kind_e kind;
    logic     dcm;
  } op_mode_t;

  // Priority: overrides first, then deep sleep, then the power-state request.
  function automatic op_mode_t decide(input logic full_req, input logic deep,
                                      input logic moving, input logic limit);
    op_mode_t m;
    m.single = 1'b0;
    m.kind   = OP_PWM;
    m.dcm    = 1'b0;
    if (moving || limit) begin
      m.single = 1'b0;
    end else if (deep) begin
      m.single = 1'b1;
      m.kind   = OP_RPM;
      m.dcm    = 1'b1;
    end else if (!full_req) begin
      m.single = 1'b1;
      m.kind   = OP_RPM;
    end
    return m;
  endfunction

endpackage

// File: rtl/phase_detect.sv
module phase_detect #(
  parameter int NPH       = 3,
  parameter int DET_TICKS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NPH-2:0] strap_hi,
  output logic [NPH-1:0] en_mask,
  output logic           done
);
  localparam int CW = $clog2(DET_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DET_TICKS - 1);

  logic [CW-1:0]  cnt;
  logic [NPH-2:0] seen;
  logic [NPH-2:0] seen_nxt;

  assign seen_nxt = seen | strap_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      seen    <= '0;
      done    <= 1'b0;
      en_mask <= '0;
    end else if (tick && !done) begin
      cnt  <= cnt + CW'(1);
      seen <= seen_nxt;
      if (cnt == LAST) begin
        done    <= 1'b1;
        en_mask <= {~seen_nxt, 1'b1};
      end
    end
  end
endmodule

// File: rtl/mode_track.sv
module mode_track
  import phase_shed_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic           full_req,
  input  logic           deep_sleep,
  input  logic           vset_moving,
  input  logic           cur_limit,
  input  logic [NPH-1:0] en_mask,
  output logic [NPH-1:0] nxt_mask,
  output logic           mode_rpm,
  output logic           dcm_ok,
  output logic           multi_en
);
  localparam logic [NPH-1:0] ONLY_FIRST = NPH'(1);

  op_mode_t nxt_op;
  op_mode_t cur_op;
  logic     nxt_multi;

  function automatic int count_set(input logic [NPH-1:0] v);
    int n = 0;
    for (int i = 0; i < NPH; i++) n += int'(v[i]);
    return n;
  endfunction

  always_comb begin
    nxt_op    = decide(full_req, deep_sleep, vset_moving, cur_limit);
    nxt_mask  = nxt_op.single ? (en_mask & ONLY_FIRST) : en_mask;
    nxt_multi = count_set(nxt_mask) > 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_op   <= '{single: 1'b0, kind: OP_PWM, dcm: 1'b0};
      multi_en <= 1'b0;
    end else if (fire) begin
      cur_op   <= nxt_op;
      multi_en <= nxt_multi;
    end
  end

  assign mode_rpm = (cur_op.kind == OP_RPM);
  assign dcm_ok   = cur_op.dcm;
endmodule

// File: rtl/interleave_rot.sv
module interleave_rot #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic [NPH-1:0] run_mask,
  output logic [NPH-1:0] ph_tick
);
  localparam int IW = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [IW-1:0] START = IW'(NPH - 1);

  logic [IW-1:0] last;
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    pick  = last;
    found = 1'b0;
    for (int k = 1; k <= NPH; k++) begin
      if (!found && run_mask[(int'(last) + k) % NPH]) begin
        pick  = IW'((int'(last) + k) % NPH);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_tick <= '0;
      last    <= START;
    end else begin
      ph_tick <= '0;
      if (fire && found) begin
        ph_tick <= NPH'(1) << pick;
        last    <= pick;
      end
    end
  end
endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl #(
  parameter int NPH       = 3,
  parameter int DET_TICKS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NPH-2:0] strap_hi,
  input  logic           full_req,
  input  logic           deep_sleep,
  input  logic           vset_moving,
  input  logic           cur_limit,
  output logic [NPH-1:0] ph_tick,
  output logic [NPH-1:0] pin_en,
  output logic           multi_en,
  output logic           mode_rpm,
  output logic           dcm_ok,
  output logic           detect_done
);
  logic [NPH-1:0] en_mask;
  logic [NPH-1:0] nxt_mask;
  logic           fire;

  phase_detect #(.NPH(NPH), .DET_TICKS(DET_TICKS)) u_det (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .strap_hi (strap_hi),
    .en_mask  (en_mask),
    .done     (detect_done)
  );

  assign fire   = tick && detect_done;
  assign pin_en = en_mask;

  mode_track #(.NPH(NPH)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .full_req    (full_req),
    .deep_sleep  (deep_sleep),
    .vset_moving (vset_moving),
    .cur_limit   (cur_limit),
    .en_mask     (en_mask),
    .nxt_mask    (nxt_mask),
    .mode_rpm    (mode_rpm),
    .dcm_ok      (dcm_ok),
    .multi_en    (multi_en)
  );

  interleave_rot #(.NPH(NPH)) u_rot (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .run_mask (nxt_mask),
    .ph_tick  (ph_tick)
  );
endmodule

// File: rtl/phase_shed_chk.sv
module phase_shed_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           vset_moving,
  input logic           cur_limit,
  input logic [NPH-1:0] ph_tick,
  input logic [NPH-1:0] pin_en,
  input logic           multi_en,
  input logic           mode_rpm,
  input logic           dcm_ok,
  input logic           detect_done
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r5_tick_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ph_tick));

  a_r5_tick_after_master: assert property (@(posedge clk) disable iff (rst)
    (armed && ph_tick != '0) |-> $past(tick));

  a_r1_quiet_before_done: assert property (@(posedge clk) disable iff (rst)
    !detect_done |-> (ph_tick == '0 && pin_en == '0 && !multi_en && !mode_rpm && !dcm_ok));

  a_r6_tick_populated: assert property (@(posedge clk) disable iff (rst)
    (ph_tick & ~pin_en) == '0);

  a_r4_pins_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && detect_done && $past(detect_done)) |-> $stable(pin_en));

  a_r12_change_on_tick: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(tick)) |-> $stable({mode_rpm, dcm_ok, multi_en}));

  a_r7_override_pwm: assert property (@(posedge clk) disable iff (rst)
    (tick && detect_done && (vset_moving || cur_limit)) |=> (!mode_rpm && !dcm_ok));

  a_r10_dcm_single: assert property (@(posedge clk) disable iff (rst)
    dcm_ok |-> (mode_rpm && !multi_en));

  a_r11_multi_needs_pins: assert property (@(posedge clk) disable iff (rst)
    multi_en |-> ($countones(pin_en) > 1));
endmodule

bind phase_shed_ctrl phase_shed_chk #(.NPH(NPH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .vset_moving (vset_moving),
  .cur_limit   (cur_limit),
  .ph_tick     (ph_tick),
  .pin_en      (pin_en),
  .multi_en    (multi_en),
  .mode_rpm    (mode_rpm),
  .dcm_ok      (dcm_ok),
  .detect_done (detect_done)
);

// File: tb/phase_shed_ctrl_tb.sv
module phase_shed_ctrl_tb;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [NPH-2:0] strap_hi = '0;
  logic full_req = 1'b1, deep_sleep = 1'b0, vset_moving = 1'b0, cur_limit = 1'b0;
  logic [NPH-1:0] ph_tick, pin_en;
  logic multi_en, mode_rpm, dcm_ok, detect_done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  phase_shed_ctrl #(.NPH(NPH), .DET_TICKS(3)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .strap_hi(strap_hi),
    .full_req(full_req), .deep_sleep(deep_sleep),
    .vset_moving(vset_moving), .cur_limit(cur_limit),
    .ph_tick(ph_tick), .pin_en(pin_en), .multi_en(multi_en),
    .mode_rpm(mode_rpm), .dcm_ok(dcm_ok), .detect_done(detect_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int last_exp;
    logic [NPH-1:0] exp_en;
    for (int cfg = 0; cfg < 4; cfg++) begin
      rst = 1'b1; tick = 1'b0; strap_hi = '0;
      full_req = 1'b1; deep_sleep = 1'b0; vset_moving = 1'b0; cur_limit = 1'b0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk({ph_tick, pin_en, multi_en, mode_rpm, dcm_ok, detect_done} == '0, "R1 reset",
          int'({ph_tick, pin_en}), 0);
      rst = 1'b0;
      @(negedge clk);
      chk({ph_tick, pin_en, multi_en, detect_done} == '0, "R1 after reset",
          int'({ph_tick, pin_en}), 0);
      // strap window: pattern cfg asserted at window tick (cfg % 3)
      for (int w = 0; w < 3; w++) begin
        strap_hi = (w == cfg % 3) ? 2'(cfg) : 2'b00;
        pulse();
        strap_hi = 2'b00;
        chk(detect_done == (w == 2), "R2 done timing", int'(detect_done), int'(w == 2));
        chk(ph_tick == '0, "R1 no tick in window", int'(ph_tick), 0);
        chk(w == 2 || pin_en == '0, "R1 pins off in window", int'(pin_en), 0);
      end
      exp_en = {~cfg[1], ~cfg[0], 1'b1};
      chk(pin_en == exp_en, "R2 R4 strap result", int'(pin_en), int'(exp_en));
      chk(!multi_en && !mode_rpm && !dcm_ok, "R11 quiet after window",
          int'({multi_en, mode_rpm, dcm_ok}), 0);
      // R3: strap input now ignored
      strap_hi = 2'b11;
      last_exp = NPH - 1;
      for (int f = 0; f < 16; f++) begin
        logic ov, single, e_rpm, e_dcm, e_multi;
        logic [NPH-1:0] mask;
        logic [NPH-1:0] pm, pd;
        logic px;
        @(negedge clk);
        pm = {1'b0, mode_rpm, dcm_ok}; px = multi_en;
        vset_moving = f[0]; cur_limit = f[1]; full_req = f[2]; deep_sleep = f[3];
        @(negedge clk);
        // R12: flag change without a tick leaves outputs unchanged
        pd = {1'b0, mode_rpm, dcm_ok};
        chk(pd == pm && multi_en == px, "R12 no change without tick",
            int'({pd, multi_en}), int'({pm, px}));
        ov = f[0] | f[1];
        single = !ov && (f[3] || !f[2]);
        e_rpm = single;
        e_dcm = !ov && f[3];
        mask = single ? 3'b001 : exp_en;
        e_multi = ($countones(mask) > 1);
        for (int t = 0; t < 4; t++) begin
          int nxt;
          logic [NPH-1:0] exp_t;
          string rq;
          nxt = last_exp;
          for (int k = NPH; k >= 1; k--)
            if (mask[(last_exp + k) % NPH]) nxt = (last_exp + k) % NPH;
          last_exp = nxt;
          exp_t = NPH'(1) << nxt;
          pulse();
          rq = ov ? "R7" : (f[3] ? "R10" : (f[2] ? "R8" : "R9"));
          chk(ph_tick == exp_t, {rq, " R6 rotation"}, int'(ph_tick), int'(exp_t));
          chk(mode_rpm == e_rpm && dcm_ok == e_dcm, {rq, " mode"},
              int'({mode_rpm, dcm_ok}), int'({e_rpm, e_dcm}));
          chk(multi_en == e_multi, "R11 multi enable", int'(multi_en), int'(e_multi));
          @(negedge clk);
          chk(ph_tick == '0, "R5 single cycle tick", int'(ph_tick), 0);
          chk(pin_en == exp_en, "R3 strap ignored", int'(pin_en), int'(exp_en));
        end
      end
    end
    finish_run();
  end
endmodule